// File: doc/BRIEF.md
# Trim Code Nonvolatile Commit and Power-Up Recall

This block keeps the stored copies of two 8-bit trim locations: the wiper code that sets a resistor-ladder tap, and a general-purpose byte. The serial bus slave stages a write here. The write is staged only when the write-enable latch is set at the moment of the request. A later valid stop then starts a timed commit cycle. During the commit the block reports busy and refuses further requests. When the commit ends, the stored copy and the live register are both updated.

Storage is modelled as registers that keep their value across a loss of power-good. While power-good is low, the live wiper is forced to the midpoint code 80h. After power-good returns, a timed recall copies both stored locations back into the live registers. The live wiper code is decoded into a one-hot tap select with one bit per ladder tap. The commit and recall lengths are parameters counted in system-clock cycles.

Top module: `nv_trim_store`

## Requirements
- R1: While reset is applied, and until the first recall completes, busy is 1, the live wiper code is 80h and the live general-purpose byte is 00h.
- R2: A write request staged with the write-enable latch at 1 (wrSel 0 selects the wiper, wrSel 1 selects the general-purpose byte) is committed by the next valid stop. Exactly COMMIT_CYC cycles after the clock edge that samples the stop, the selected live register and its stored copy take the staged data.
- R3: Busy rises on the clock edge that samples the committing stop and stays high for exactly COMMIT_CYC cycles.
- R4: A write request made with the write-enable latch at 0 stages nothing. A following stop starts no commit, busy stays 0 and both live registers keep their values.
- R5: A valid stop with no staged write has no effect on busy or on either live register.
- R6: A write request that arrives while busy is high raises dropErr for exactly one cycle and is neither staged nor committed.
- R7: On the first clock edge that samples power-good low, the live wiper becomes 80h and busy becomes 1. Both stay that way for as long as power-good stays low.
- R8: Power-good sampled high after reset or after a power loss starts a recall. RECALL_CYC cycles later both live registers hold the stored values and busy returns to 0.
- R9: A power loss during a commit aborts the commit: the stored copy keeps its old value, and the next recall shows that value.
- R10: tapSel is one-hot, and its single set bit sits at the index equal to the live wiper code: code 00h sets bit 0 and code FFh sets bit 255.
- R11: A commit changes only the location that wrSel selected; the other location keeps its value.
- R12: When several enabled write requests come before a stop, only the last one is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; loads the factory values into storage |
| pwrGood | input | 1 | Supply-good indication; low forces the midpoint wiper |
| wrReq | input | 1 | One-cycle write request from the bus slave |
| wrSel | input | 1 | Location select: 0 wiper code, 1 general-purpose byte |
| wrData | input | 8 | Data to stage |
| wrEnLatch | input | 1 | Write-enable latch state at the time of the request |
| stopValid | input | 1 | One-cycle pulse for a valid stop that ends the write |
| busy | output | 1 | High during recall, commit and power loss |
| dropErr | output | 1 | One-cycle flag for a request refused while busy |
| wiperCode | output | 8 | Live wiper code |
| gpByte | output | 8 | Live general-purpose byte |
| tapSel | output | 256 | One-hot tap select decoded from the live wiper code |

## Verification
The bench measures the exact commit and recall windows. A counter that is off by one would move the update or the fall of busy by a cycle, and the bench would see it. It sends a request in the middle of a commit. A design that accepts that request would show dropErr staying low, or would commit the late data instead of the data that was staged first. It also removes power in the middle of a commit and then waits for the recall. A design that writes storage too early would bring back the aborted value instead of the old one. It tries writes with the latch clear and stops with nothing staged. A design that commits in either case would raise busy or change a register. It also checks the tap select at both ends of the code range and at points in between.

// File: rtl/nvts_pkg.sv
package nvts_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_RECALL = 2'd1,
    ST_IDLE   = 2'd2,
    ST_COMMIT = 2'd3
  } nvState_t;

  // strobes from control to datapath, one per datapath action
  typedef struct packed {
    logic stage;     // capture select and data of an enabled request
    logic commit;    // commit cycle ends: write store and live copy
    logic recall;    // recall ends: copy store into live registers
    logic forceMid;  // supply lost: park wiper at midpoint
  } nvStrobe_t;
endpackage

// File: rtl/nvts_ctrl.sv
module nvts_ctrl
  import nvts_pkg::*;
#(
  parameter int RECALL_CYC = 50000,
  parameter int COMMIT_CYC = 500000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pwrGood,
  input  logic      wrReq,
  input  logic      wrEnLatch,
  input  logic      stopValid,
  output nvStrobe_t strobe,
  output logic      busy,
  output logic      dropErr
);
  localparam int MAX_CYC = (RECALL_CYC > COMMIT_CYC) ? RECALL_CYC : COMMIT_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RECALL_LAST = CNT_W'(RECALL_CYC - 1);
  localparam logic [CNT_W-1:0] COMMIT_LAST = CNT_W'(COMMIT_CYC - 1);

  nvState_t         state;
  logic [CNT_W-1:0] cnt;
  logic             pend;
  logic             startCommit;

  assign busy        = (state != ST_IDLE);
  assign startCommit = pwrGood && (state == ST_IDLE) && stopValid && pend;

  always_comb begin
    strobe          = '0;
    strobe.forceMid = !pwrGood;
    strobe.recall   = pwrGood && (state == ST_RECALL) && (cnt == RECALL_LAST);
    strobe.commit   = pwrGood && (state == ST_COMMIT) && (cnt == COMMIT_LAST);
    strobe.stage    = pwrGood && (state == ST_IDLE) && wrReq && wrEnLatch && !startCommit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      cnt     <= '0;
      pend    <= 1'b0;
      dropErr <= 1'b0;
    end else begin
      dropErr <= wrReq && busy;
      if (!pwrGood) begin
        state <= ST_OFF;
        cnt   <= '0;
        pend  <= 1'b0;
      end else begin
        unique case (state)
          ST_OFF: begin
            state <= ST_RECALL;
            cnt   <= '0;
          end
          ST_RECALL: begin
            if (cnt == RECALL_LAST) state <= ST_IDLE;
            else                    cnt   <= cnt + 1'b1;
          end
          ST_IDLE: begin
            if (startCommit) begin
              state <= ST_COMMIT;
              cnt   <= '0;
              pend  <= 1'b0;
            end else if (strobe.stage) begin
              pend  <= 1'b1;
            end
          end
          ST_COMMIT: begin
            if (cnt == COMMIT_LAST) state <= ST_IDLE;
            else                    cnt   <= cnt + 1'b1;
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/nvts_data.sv
module nvts_data
  import nvts_pkg::*;
#(
  parameter int              CODE_W     = 8,
  parameter int              NUM_LOC    = 2,
  parameter logic [CODE_W-1:0] WIPER_INIT = 8'h80,
  parameter logic [CODE_W-1:0] GP_INIT    = 8'h00
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  nvStrobe_t                  strobe,
  input  logic [$clog2(NUM_LOC)-1:0] wrSel,
  input  logic [CODE_W-1:0]          wrData,
  output logic [CODE_W-1:0]          wiperCode,
  output logic [CODE_W-1:0]          gpByte
);
  localparam int SEL_W = $clog2(NUM_LOC);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] store [NUM_LOC];
  logic [CODE_W-1:0] live  [NUM_LOC];
  logic [SEL_W-1:0]  stageSel;
  logic [CODE_W-1:0] stageData;

  function automatic logic [CODE_W-1:0] factoryVal(input int idx);
    return (idx == 0) ? WIPER_INIT : GP_INIT;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageSel  <= '0;
      stageData <= '0;
      for (int i = 0; i < NUM_LOC; i++) begin
        store[i] <= factoryVal(i);
        live[i]  <= (i == 0) ? MID_CODE : '0;
      end
    end else begin
      if (strobe.stage) begin
        stageSel  <= wrSel;
        stageData <= wrData;
      end
      for (int i = 0; i < NUM_LOC; i++) begin
        if (strobe.forceMid) begin
          if (i == 0) live[i] <= MID_CODE;
        end else if (strobe.recall) begin
          live[i] <= store[i];
        end else if (strobe.commit && (stageSel == SEL_W'(i))) begin
          store[i] <= stageData;
          live[i]  <= stageData;
        end
      end
    end
  end

  assign wiperCode = live[0];
  assign gpByte    = live[1];
endmodule

// File: rtl/nvts_tapdec.sv
module nvts_tapdec #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0]         code,
  output logic [(1 << CODE_W)-1:0]  tapSel
);
  localparam int TAPS = 1 << CODE_W;

  for (genvar t = 0; t < TAPS; t++) begin : gTap
    assign tapSel[t] = (code == CODE_W'(t));
  end
endmodule

// File: rtl/nv_trim_store.sv
module nv_trim_store
  import nvts_pkg::*;
#(
  parameter int         RECALL_CYC = 50000,
  parameter int         COMMIT_CYC = 500000,
  parameter logic [7:0] WIPER_INIT = 8'h80,
  parameter logic [7:0] GP_INIT    = 8'h00
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pwrGood,
  input  logic         wrReq,
  input  logic         wrSel,
  input  logic [7:0]   wrData,
  input  logic         wrEnLatch,
  input  logic         stopValid,
  output logic         busy,
  output logic         dropErr,
  output logic [7:0]   wiperCode,
  output logic [7:0]   gpByte,
  output logic [255:0] tapSel
);
  nvStrobe_t strobe;

  nvts_ctrl #(
    .RECALL_CYC(RECALL_CYC),
    .COMMIT_CYC(COMMIT_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .wrReq(wrReq),
    .wrEnLatch(wrEnLatch), .stopValid(stopValid),
    .strobe(strobe), .busy(busy), .dropErr(dropErr)
  );

  nvts_data #(
    .CODE_W(8), .NUM_LOC(2),
    .WIPER_INIT(WIPER_INIT), .GP_INIT(GP_INIT)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSel(wrSel), .wrData(wrData),
    .wiperCode(wiperCode), .gpByte(gpByte)
  );

  nvts_tapdec #(.CODE_W(8)) uTap (
    .code(wiperCode), .tapSel(tapSel)
  );
endmodule

// File: rtl/nv_trim_store_chk.sv
module nv_trim_store_chk (
  input logic         clk,
  input logic         rstN,
  input logic         pwrGood,
  input logic         wrReq,
  input logic         busy,
  input logic         dropErr,
  input logic [7:0]   wiperCode,
  input logic [255:0] tapSel
);
  AST_TAP_ONE_HOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSel) == 1);                                          // R10

  AST_MID_ON_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> (wiperCode == 8'h80));                                // R7

  AST_BUSY_ON_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    !pwrGood |=> busy);                                                // R7

  AST_DROP_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    dropErr |-> $past(wrReq && busy));                                 // R6

  AST_WIPER_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(wiperCode));                   // R4
endmodule

bind nv_trim_store nv_trim_store_chk uChk (
  .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .wrReq(wrReq), .busy(busy),
  .dropErr(dropErr), .wiperCode(wiperCode), .tapSel(tapSel)
);

// File: tb/nv_trim_store_test.sv
module nv_trim_store_test;
  localparam int CLK_PERIOD = 10;
  localparam int RC = 4;
  localparam int CC = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         pwrGood = 1'b1;
  logic         wrReq = 1'b0;
  logic         wrSel = 1'b0;
  logic [7:0]   wrData = 8'h00;
  logic         wrEnLatch = 1'b0;
  logic         stopValid = 1'b0;
  logic         busy, dropErr;
  logic [7:0]   wiperCode, gpByte;
  logic [255:0] tapSel;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [7:0] w;
    logic [7:0] g;
    logic       b;
    logic       d;
    string      tag;
  } expItem_t;
  expItem_t q[$];

  nv_trim_store #(
    .RECALL_CYC(RC), .COMMIT_CYC(CC), .WIPER_INIT(8'h5A), .GP_INIT(8'hA5)
  ) uut (
    .clk(clk), .rstN(rstN), .pwrGood(pwrGood), .wrReq(wrReq), .wrSel(wrSel),
    .wrData(wrData), .wrEnLatch(wrEnLatch), .stopValid(stopValid),
    .busy(busy), .dropErr(dropErr), .wiperCode(wiperCode), .gpByte(gpByte),
    .tapSel(tapSel)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc++;

  // monitor: compares the outputs against every item due in this cycle
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].at == cyc) begin
        total++;
        if (wiperCode !== q[i].w || gpByte !== q[i].g || busy !== q[i].b || dropErr !== q[i].d) begin
          bad++;
          $display("FAIL %s cyc=%0d got w=%h g=%h busy=%b drop=%b exp w=%h g=%h busy=%b drop=%b",
                   q[i].tag, cyc, wiperCode, gpByte, busy, dropErr,
                   q[i].w, q[i].g, q[i].b, q[i].d);
        end
        q.delete(i);
      end
    end
  end

  task automatic expectAt(input int k, input logic [7:0] w, input logic [7:0] g,
                          input logic b, input logic d, input string tag);
    expItem_t it;
    it.at = cyc + k; it.w = w; it.g = g; it.b = b; it.d = d; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic sel, input logic [7:0] d, input logic wel);
    wrReq = 1'b1; wrSel = sel; wrData = d; wrEnLatch = wel;
    step(1);
    wrReq = 1'b0; wrEnLatch = 1'b0;
  endtask

  task automatic doStop();
    stopValid = 1'b1;
    step(1);
    stopValid = 1'b0;
  endtask

  task automatic checkTap(input logic [7:0] code, input string tag);
    logic [255:0] exp;
    exp = 256'b1 << code;
    total++;
    if (tapSel !== exp) begin
      bad++;
      $display("FAIL %s tap got bit count %0d sel[%0d]=%b exp one-hot at %0d",
               tag, $countones(tapSel), code, tapSel[code], code);
    end
  endtask

  logic [7:0] expW, expG;

  initial begin
    step(3);
    total++;
    if (busy !== 1'b1 || wiperCode !== 8'h80 || gpByte !== 8'h00) begin
      bad++;
      $display("FAIL R1 in reset got busy=%b w=%h g=%h exp busy=1 w=80 g=00", busy, wiperCode, gpByte);
    end
    rstN = 1'b1;
    expectAt(RC, 8'h80, 8'h00, 1'b1, 1'b0, "R1 before recall");
    expectAt(RC + 1, 8'h5A, 8'hA5, 1'b0, 1'b0, "R8 first recall");
    step(RC + 2);
    expW = 8'h5A; expG = 8'hA5;
    checkTap(expW, "R10 after recall");

    // R2 R3: enabled wiper write then stop
    doWrite(1'b0, 8'h12, 1'b1);
    expectAt(1, expW, expG, 1'b1, 1'b0, "R3 busy start");
    expectAt(CC, expW, expG, 1'b1, 1'b0, "R3 busy last");
    expectAt(CC + 1, 8'h12, expG, 1'b0, 1'b0, "R2 wiper commit");
    doStop();
    step(CC + 1);
    expW = 8'h12;
    checkTap(expW, "R10 code 12h");

    // R11: general-purpose byte only
    doWrite(1'b1, 8'h77, 1'b1);
    expectAt(CC + 1, expW, 8'h77, 1'b0, 1'b0, "R11 gp commit");
    doStop();
    step(CC + 1);
    expG = 8'h77;

    // R4: latch clear
    doWrite(1'b0, 8'h99, 1'b0);
    expectAt(1, expW, expG, 1'b0, 1'b0, "R4 no busy");
    expectAt(CC + 1, expW, expG, 1'b0, 1'b0, "R4 no change");
    doStop();
    step(CC + 1);

    // R5: bare stop
    expectAt(1, expW, expG, 1'b0, 1'b0, "R5 bare stop");
    expectAt(3, expW, expG, 1'b0, 1'b0, "R5 bare stop later");
    doStop();
    step(3);

    // R12: last staged request wins, top code
    doWrite(1'b0, 8'h40, 1'b1);
    doWrite(1'b0, 8'hFF, 1'b1);
    expectAt(CC + 1, 8'hFF, expG, 1'b0, 1'b0, "R12 last wins");
    doStop();
    step(CC + 1);
    expW = 8'hFF;
    checkTap(expW, "R10 code FFh");
    doWrite(1'b0, 8'h00, 1'b1);
    doStop();
    step(CC + 1);
    expW = 8'h00;
    checkTap(expW, "R10 code 00h");

    // R6: request during commit dropped
    doWrite(1'b0, 8'h30, 1'b1);
    expectAt(1, expW, expG, 1'b1, 1'b0, "R6 busy");
    expectAt(2, expW, expG, 1'b1, 1'b1, "R6 drop pulse");
    expectAt(3, expW, expG, 1'b1, 1'b0, "R6 drop one cycle");
    expectAt(CC + 1, 8'h30, expG, 1'b0, 1'b0, "R6 first data kept");
    doStop();
    doWrite(1'b0, 8'h55, 1'b1);
    step(CC);
    expW = 8'h30;
    expectAt(1, expW, expG, 1'b0, 1'b0, "R6 dropped not staged");
    expectAt(CC + 1, expW, expG, 1'b0, 1'b0, "R6 dropped not committed");
    doStop();
    step(CC + 1);

    // R7 R8: power loss and recall
    pwrGood = 1'b0;
    expectAt(1, 8'h80, expG, 1'b1, 1'b0, "R7 mid on loss");
    expectAt(3, 8'h80, expG, 1'b1, 1'b0, "R7 mid held");
    expectAt(RC + 3, 8'h80, expG, 1'b1, 1'b0, "R8 recall pending");
    expectAt(RC + 4, expW, expG, 1'b0, 1'b0, "R8 recall loads");
    step(3);
    pwrGood = 1'b1;
    step(RC + 2);
    checkTap(expW, "R10 after second recall");

    // R9: power lost during commit
    doWrite(1'b0, 8'h66, 1'b1);
    doStop();
    step(2);
    pwrGood = 1'b0;
    expectAt(1, 8'h80, expG, 1'b1, 1'b0, "R7 loss in commit");
    step(1);
    pwrGood = 1'b1;
    expectAt(RC, 8'h80, expG, 1'b1, 1'b0, "R9 recall pending");
    expectAt(RC + 1, expW, expG, 1'b0, 1'b0, "R9 store kept");
    step(RC + 3);

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard left %0d items, exp 0", q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got running exp done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule